// File: doc/BRIEF.md
# PHY Register Access Bridge

This block lets a host bus reach a small internal PHY register file through a single 32-bit control and status word. The host writes the word once to start an access. The write carries the direction, an 8-bit register address and, for a write, 16 bits of data. The bridge then runs one request/acknowledge transaction toward the PHY register file and holds a busy flag for as long as that transaction runs.

The host finishes the access by polling the same word until the busy flag drops. After a read, the returned register value appears in the upper half of the word. The PHY side may take any number of cycles to acknowledge. The bridge adds one cycle of its own at each end, so completion stays far inside the host's millisecond-scale polling timeout.

Top module: `phy_reg_bridge`

## Requirements
- R1: After reset the status word reads all zeros and the PHY request output is low.
- R2: A host write accepted while idle sets the busy flag (bit 7) in the next cycle. The word then shows the operation bit (bit 0, 1 = PHY write, 0 = PHY read) and the address field (bits 15:8) taken from that host write.
- R3: While the PHY request is high, the request stays high until an acknowledge is sampled, and the direction, address and write data presented to the PHY stay stable.
- R4: Busy clears, and the request drops, at the clock edge that samples the acknowledge. With a PHY that acknowledges L cycles after the request first appears, busy reads 1 for exactly L+1 cycles.
- R5: On completion of a PHY read, bits 31:16 take the acknowledged read data at the same edge that busy clears, and bits 15:8 keep the address.
- R6: On completion of a PHY write, bits 31:16 keep the data written by the host and the PHY register file receives that data at that address.
- R7: A host write while busy is set is ignored: the in-flight transaction, the PHY-side address, direction and data, and the final status word are unchanged.
- R8: Bit 7 cannot be written by the host, and bits 6:1 always read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe for the control word |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Current control/status word |
| phy_req | output | 1 | Transaction request toward the PHY register file |
| phy_we | output | 1 | 1 = PHY register write, 0 = PHY register read |
| phy_addr | output | 8 | PHY register address |
| phy_wdata | output | 16 | PHY register write data |
| phy_ack | input | 1 | Transaction acknowledge from the PHY register file |
| phy_rdata | input | 16 | PHY register read data, valid with the acknowledge |

## Verification
Writes and reads are mixed over acknowledge latencies of 1, 2, 3, 5 and 16 cycles. The busy-length count then separates a bridge that waits for the acknowledge from one that finishes on a fixed delay. Reading back an address that was just written shows whether write data truly reached the PHY. Reading an untouched address shows whether the captured data comes from the PHY rather than from the word the host wrote. A host write issued mid-transaction with a different address, direction and data shows whether the busy lockout holds. A word with the reserved and busy bits set shows whether those bits are really read-only.

// File: rtl/phy_bridge_pkg.sv
package phy_bridge_pkg;
  // Bit positions inside the control/status word that the host software decodes.
  localparam int unsigned OP_BIT   = 0;
  localparam int unsigned BUSY_BIT = 7;
  localparam int unsigned ADDR_LSB = 8;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_WAIT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/phy_bridge_seq.sv
module phy_bridge_seq
  import phy_bridge_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic phy_ack,
  output logic phy_req,
  output logic done
);
  seq_state_e state_q;

  assign phy_req = (state_q == SEQ_WAIT);
  assign done    = phy_req & phy_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      case (state_q)
        SEQ_IDLE: if (start) state_q <= SEQ_WAIT;
        SEQ_WAIT: if (phy_ack) state_q <= SEQ_IDLE;
        default:  state_q <= SEQ_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req && !phy_ack |=> phy_req); // R3
  AST_ACK_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !phy_req); // R4
endmodule

// File: rtl/phy_bridge_csr.sv
module phy_bridge_csr
  import phy_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned DATA_LSB = ADDR_LSB + ADDR_W,
  localparam int unsigned WORD_W   = DATA_LSB + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wdata,
  input  logic              done,
  input  logic [DATA_W-1:0] phy_rdata,
  output logic              start,
  output logic              busy,
  output logic              op_write,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data,
  output logic [WORD_W-1:0] word
);
  // Assemble the host-visible word; unlisted bits read as zero.
  function automatic logic [WORD_W-1:0] pack_word(
    input logic op, input logic bsy,
    input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    logic [WORD_W-1:0] w;
    w = '0;
    w[OP_BIT]              = op;
    w[BUSY_BIT]            = bsy;
    w[ADDR_LSB +: ADDR_W]  = a;
    w[DATA_LSB +: DATA_W]  = d;
    return w;
  endfunction

  logic capture_rd;

  assign start      = host_wr & ~busy;
  assign capture_rd = done & ~op_write;
  assign word       = pack_word(op_write, busy, addr, data);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      op_write <= 1'b0;
      addr     <= '0;
      data     <= '0;
    end else if (start) begin
      busy     <= 1'b1;
      op_write <= host_wdata[OP_BIT];
      addr     <= host_wdata[ADDR_LSB +: ADDR_W];
      data     <= host_wdata[DATA_LSB +: DATA_W];
    end else if (done) begin
      busy <= 1'b0;
      if (capture_rd) data <= phy_rdata;
    end
  end

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && !busy |=> busy); // R2
  AST_BUSY_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && busy |=> $stable(addr) && $stable(op_write)); // R7
  AST_RD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    capture_rd |=> !busy && data == $past(phy_rdata) && $stable(addr)); // R5
  AST_WR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    done && op_write |=> !busy && $stable(data)); // R6
  AST_RO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && host_wdata[BUSY_BIT:1] != '0 |=> word[BUSY_BIT-1:1] == '0); // R8
endmodule

// File: rtl/phy_reg_bridge.sv
module phy_reg_bridge #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned WORD_W = phy_bridge_pkg::ADDR_LSB + ADDR_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [WORD_W-1:0] host_wdata,
  output logic [WORD_W-1:0] host_rdata,
  output logic              phy_req,
  output logic              phy_we,
  output logic [ADDR_W-1:0] phy_addr,
  output logic [DATA_W-1:0] phy_wdata,
  input  logic              phy_ack,
  input  logic [DATA_W-1:0] phy_rdata
);
  logic start;
  logic done;
  logic busy;

  phy_bridge_csr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_csr (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .done       (done),
    .phy_rdata  (phy_rdata),
    .start      (start),
    .busy       (busy),
    .op_write   (phy_we),
    .addr       (phy_addr),
    .data       (phy_wdata),
    .word       (host_rdata)
  );

  phy_bridge_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .phy_ack (phy_ack),
    .phy_req (phy_req),
    .done    (done)
  );

  AST_BUSY_COVERS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req |-> busy); // R4
  AST_PHY_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    phy_req && !phy_ack |=> $stable(phy_addr) && $stable(phy_we) && $stable(phy_wdata)); // R3
endmodule

// File: tb/tb_phy_reg_bridge.sv
module tb_phy_reg_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        phy_req, phy_we, phy_ack;
  logic [7:0]  phy_addr;
  logic [15:0] phy_wdata, phy_rdata;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  phy_reg_bridge dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .phy_req(phy_req), .phy_we(phy_we),
    .phy_addr(phy_addr), .phy_wdata(phy_wdata), .phy_ack(phy_ack),
    .phy_rdata(phy_rdata)
  );

  // Seed contents of a PHY register, used by both the PHY model and the scoreboard.
  function automatic logic [15:0] seed(input int a);
    return 16'(a * 16'h0101) ^ 16'h5A3C;
  endfunction

  // PHY register file model with a configurable acknowledge latency.
  logic [15:0] phy_mem [256];
  int          lat = 1;
  int          cnt = 0;
  assign phy_rdata = phy_mem[phy_addr];

  initial for (int i = 0; i < 256; i++) phy_mem[i] = seed(i);

  always @(posedge clk) begin
    if (phy_req && !phy_ack) begin
      if (cnt >= lat - 1) begin
        phy_ack <= 1'b1;
        cnt     <= 0;
      end else begin
        cnt <= cnt + 1;
      end
    end else begin
      phy_ack <= 1'b0;
    end
    if (phy_req && phy_ack && phy_we) phy_mem[phy_addr] <= phy_wdata;
  end
  initial phy_ack = 1'b0;

  // Scoreboard copy of the register file and queue of expected final words.
  logic [15:0] exp_mem [256];
  logic [31:0] exp_q [$];
  string       tag_q [$];
  initial for (int i = 0; i < 256; i++) exp_mem[i] = seed(i);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: pops an expected word each time busy falls.
  logic prev_busy = 1'b0;
  always @(negedge clk) begin
    if (prev_busy && !host_rdata[7]) begin
      if (exp_q.size() == 0) check("R4 unexpected completion", 32'h1, 32'h0);
      else check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
    end
    prev_busy = host_rdata[7];
  end

  task automatic host_write(input logic [31:0] w);
    host_wr    = 1'b1;
    host_wdata = w;
    @(negedge clk);
    host_wr    = 1'b0;
    host_wdata = '0;
  endtask

  task automatic wait_idle(input int l, input string tag);
    int n = 0;
    while (host_rdata[7]) begin
      n++;
      @(negedge clk);
    end
    check({tag, " busy cycles"}, 32'(n), 32'(l + 1));
  endtask

  // Driver: one full access, pushing the expected final word for the monitor.
  task automatic access(input logic wr, input logic [7:0] a, input logic [15:0] d, input int l);
    logic [15:0] fin;
    lat = l;
    if (wr) begin
      exp_mem[a] = d;
      fin = d;
      exp_q.push_back({fin, a, 8'h00} | 32'h1);
      tag_q.push_back("R6 write completion word");
    end else begin
      fin = exp_mem[a];
      exp_q.push_back({fin, a, 8'h00});
      tag_q.push_back("R5 read completion word");
    end
    @(negedge clk);
    host_write({d, a, 7'b0, wr});
    check("R2 busy/op/addr after write", {16'h0, host_rdata[15:0]}, {16'h0, a, 7'b1000000, wr});
    check("R3 phy side request", {phy_req, phy_we, phy_addr, phy_wdata}, {1'b1, wr, a, d});
    wait_idle(l, wr ? "R4 write" : "R4 read");
    check("R4 request dropped", 32'(phy_req), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset word", host_rdata, 32'h0);
    check("R1 reset request", 32'(phy_req), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 word after reset release", host_rdata, 32'h0);

    access(1'b1, 8'h20, 16'hBEEF, 1);
    access(1'b0, 8'h20, 16'h0000, 3);
    access(1'b0, 8'h0B, 16'hFFFF, 16);
    access(1'b0, 8'hFF, 16'h1234, 5);
    access(1'b1, 8'h00, 16'h0000, 2);
    access(1'b0, 8'h00, 16'hAAAA, 1);
    check("R6 phy register updated", 32'(phy_mem[8'h20]), 32'hBEEF);

    // R7: a host write issued mid-transaction is ignored.
    lat = 10;
    exp_q.push_back({exp_mem[8'h37], 8'h37, 8'h00});
    tag_q.push_back("R7 final word after ignored write");
    host_write({16'h1111, 8'h37, 8'h00});
    @(negedge clk);
    host_write({16'h2222, 8'h99, 8'h01});
    check("R7 word unchanged by busy write",
          {16'h0, host_rdata[15:0]}, {16'h0, 8'h37, 8'h80});
    check("R7 phy side unchanged", {phy_req, phy_we, phy_addr, phy_wdata}, {1'b1, 1'b0, 8'h37, 16'h1111});
    wait_idle(8, "R7");
    check("R7 ignored write never reached phy", 32'(phy_mem[8'h99]), 32'(seed(8'h99)));

    // R8: reserved and busy bits in the host word have no effect.
    lat = 2;
    exp_q.push_back({exp_mem[8'h44], 8'h44, 8'h00});
    tag_q.push_back("R8 final word with reserved bits written");
    host_write({16'h5555, 8'h44, 8'hFE});
    check("R8 reserved bits read zero", 32'(host_rdata[6:1]), 32'h0);
    wait_idle(2, "R8");
    check("R8 busy not writable", 32'(host_rdata[7]), 32'h0);

    repeat (3) @(negedge clk);
    check("R4 scoreboard drained", 32'(exp_q.size()), 32'h0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(negedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule